// File: doc/BRIEF.md
# Clock Source Command Controller

This block is the register-mapped front end that decides which clock source runs the chip. Software does not write the active source directly. It first fills a select register with a source number and a start-up time code. It then issues a command through a control/status register. Each command must come straight after an unlock write, and only a short window is allowed for it. The oscillators and the glitch-free clock multiplexer sit outside the block. The oscillators are reached through per-source enable outputs and ready inputs. The multiplexer is reached through a request/acknowledge pair.

An enable command starts the selected oscillator, and the ready flag reports when that oscillator is stable. A switch command asks the multiplexer to move to the selected source. The active source changes only when the multiplexer acknowledges. A recover command copies the active source number into the select register so that software can read it, and software polls with it until a switch has completed. A disable command stops an oscillator, but it is refused for the source that is currently clocking the system. One further command sets a sticky request that puts the external watchdog into auto-reload mode.

A three-state machine (ST_IDLE, ST_WAIT_READY, ST_SWITCHING) sequences the commands. The transitions are:
- ST_IDLE to ST_WAIT_READY on an accepted enable.
- ST_WAIT_READY to ST_IDLE when the target reports ready.
- ST_IDLE to ST_SWITCHING on an accepted switch.
- ST_SWITCHING to ST_IDLE on the multiplexer acknowledge.

Top module: `clksrc_cmd_ctrl`

## Requirements
- R1: After reset, the active source is 0, only enable bit 0 is set, the ready flag is clear, the auto-reload request is low, the unlock window is closed and the state is ST_IDLE.
- R2: Writing exactly 0x80 to the control register (address 0) opens the unlock window. A command write is accepted only if it is the next bus write and it lands on one of the 4 clock cycles that follow the unlock write. Any other write closes the window. While the window is closed, command writes change nothing.
- R3: A command is a control write with bits 7:4 clear. Its low nibble selects the action: 0x1 disable, 0x2 enable, 0x4 switch, 0x5 recover, 0x6 watchdog auto-reload. Any other code has no effect.
- R4: The select register (address 1) holds the source number in bits 3:0 and the start-up code in bits 5:4. It reads back in those positions, with bits 7:6 always zero.
- R5: Enable (taken in ST_IDLE) sets the enable bit of the selected source and clears the ready flag. The ready flag rises on the clock after that source's ready input is seen high. A control read returns the unlock window in bit 7, ST_SWITCHING in bit 6, ST_WAIT_READY in bit 5 and the ready flag in bit 4, with bits 3:0 zero.
- R6: Switch (taken in ST_IDLE) to an enabled source raises mux_req with mux_target set to that source. active_src changes only on the clock that samples mux_acknowledge. A switch to a disabled source is ignored.
- R7: Recover is accepted in every state, including during a switch. It writes the source number that is active at that moment into select bits 3:0 and leaves bits 5:4 unchanged.
- R8: Disable clears the enable bit of the selected source, except when that source is the active one. The active source is always enabled.
- R9: While in ST_WAIT_READY or ST_SWITCHING, the enable, switch and disable commands are ignored. mux_req and mux_target hold until the acknowledge.
- R10: The watchdog auto-reload command sets wdog_autoreload, which then stays high until reset.
- R11: Enable, switch and disable that name a source number of NSRC or above are ignored.
- R12: osc_startup presents the start-up code that was captured by the most recent accepted enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 1 | 0 = control/status, 1 = select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| src_ready | input | NSRC | Per-oscillator stable indication |
| mux_ack | input | 1 | Multiplexer finished the switch |
| src_en | output | NSRC | Per-oscillator enable |
| osc_startup | output | 2 | Start-up time code for the starting oscillator |
| mux_req | output | 1 | Switch request to the clock multiplexer |
| mux_target | output | 4 | Source the multiplexer is asked to select |
| active_src | output | 4 | Source currently clocking the system |
| wdog_autoreload | output | 1 | Sticky request for watchdog auto-reload |

## Verification
Each command is issued with the unlock gap set to 1 cycle and to 4 cycles, which are both accepted. It is also issued with a gap of 5 cycles and with a select write between the unlock and the command, which are both refused. This tells apart a window that counts bus clocks from one that only looks at the order of writes. The bench also sends enables while an earlier enable is still waiting, switches to a disabled source, disables the active source, uses out-of-range numbers and invalid codes, and recovers in the middle of a switch. Together these separate a command that is ignored from one that is only delayed, and show whether recover reports the old source before the acknowledge and the new one after it. Oscillators start with different delays, and the multiplexer acknowledges after a fixed latency. A behavioural model follows every cycle, so any early or late change of the ready flag or of the active source is caught.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

    localparam int SRC_W  = 4;
    localparam int SUT_W  = 2;
    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] UNLOCK_WORD = 8'h80;

    typedef enum logic [3:0] {
        CMD_DISABLE  = 4'h1,
        CMD_ENABLE   = 4'h2,
        CMD_SWITCH   = 4'h4,
        CMD_RECOVER  = 4'h5,
        CMD_WDOG_ARL = 4'h6
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_READY = 2'd1,
        ST_SWITCHING  = 2'd2
    } state_e;

endpackage

// File: rtl/clksrc_guard.sv
module clksrc_guard
    import clksrc_pkg::*;
#(
    parameter int WIN_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              win_open,
    output logic              cmd_fire,
    output logic [3:0]        cmd_code
);

    localparam int CNT_W = $clog2(WIN_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYCLES);

    logic [CNT_W-1:0] win_cnt_q;
    logic             ctrl_wr;
    logic             unlock_wr;

    assign ctrl_wr   = bus_wr && !bus_addr;
    assign unlock_wr = ctrl_wr && (bus_wdata == UNLOCK_WORD);
    assign win_open  = (win_cnt_q != '0);
    assign cmd_fire  = ctrl_wr && win_open && (bus_wdata[7:4] == 4'h0);
    assign cmd_code  = bus_wdata[3:0];

    // Unlock loads the counter; any other write spends the window.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt_q <= '0;
        end else if (unlock_wr) begin
            win_cnt_q <= CNT_LOAD;
        end else if (bus_wr) begin
            win_cnt_q <= '0;
        end else if (win_open) begin
            win_cnt_q <= win_cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/clksrc_fsm.sv
module clksrc_fsm
    import clksrc_pkg::*;
#(
    parameter int NSRC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_fire,
    input  logic [3:0]       cmd_code,
    input  logic [SRC_W-1:0] sel_num,
    input  logic [SUT_W-1:0] sel_sut,
    input  logic [NSRC-1:0]  src_ready,
    input  logic             mux_ack,
    output logic [NSRC-1:0]  src_en,
    output logic [SRC_W-1:0] active_src,
    output logic [SRC_W-1:0] tgt_src,
    output state_e           state,
    output logic             rdy_flag,
    output logic [SUT_W-1:0] sut_out,
    output logic             arl_req
);

    state_e           st_q, st_d;
    logic [NSRC-1:0]  en_q, en_d;
    logic [SRC_W-1:0] act_q, act_d;
    logic [SRC_W-1:0] tgt_q, tgt_d;
    logic             rdy_q, rdy_d;
    logic [SUT_W-1:0] sut_q, sut_d;
    logic             arl_q, arl_d;

    logic [NSRC-1:0]  sel_oh;
    logic [NSRC-1:0]  tgt_oh;

    // One-hot decode; numbers >= NSRC decode to zero.
    for (genvar i = 0; i < NSRC; i++) begin : g_dec
        assign sel_oh[i] = (sel_num == SRC_W'(i));
        assign tgt_oh[i] = (tgt_q   == SRC_W'(i));
    end

    logic sel_valid;
    logic sel_enabled;
    logic tgt_ready;

    assign sel_valid   = |sel_oh;
    assign sel_enabled = |(sel_oh & en_q);
    assign tgt_ready   = |(tgt_oh & src_ready);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            en_q  <= NSRC'(1);
            act_q <= '0;
            tgt_q <= '0;
            rdy_q <= 1'b0;
            sut_q <= '0;
            arl_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            en_q  <= en_d;
            act_q <= act_d;
            tgt_q <= tgt_d;
            rdy_q <= rdy_d;
            sut_q <= sut_d;
            arl_q <= arl_d;
        end
    end

    // Next state and data
    always_comb begin
        st_d  = st_q;
        en_d  = en_q;
        act_d = act_q;
        tgt_d = tgt_q;
        rdy_d = rdy_q;
        sut_d = sut_q;
        arl_d = arl_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_fire) begin
                    case (cmd_code)
                        CMD_ENABLE: begin
                            if (sel_valid) begin
                                en_d  = en_q | sel_oh;
                                rdy_d = 1'b0;
                                tgt_d = sel_num;
                                sut_d = sel_sut;
                                st_d  = ST_WAIT_READY;
                            end
                        end
                        CMD_SWITCH: begin
                            if (sel_enabled) begin
                                tgt_d = sel_num;
                                st_d  = ST_SWITCHING;
                            end
                        end
                        CMD_DISABLE: begin
                            if (sel_valid && (sel_num != act_q)) begin
                                en_d = en_q & ~sel_oh;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_WAIT_READY: begin
                if (tgt_ready) begin
                    rdy_d = 1'b1;
                    st_d  = ST_IDLE;
                end
            end
            ST_SWITCHING: begin
                if (mux_ack) begin
                    act_d = tgt_q;
                    st_d  = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
        if (cmd_fire && (cmd_code == CMD_WDOG_ARL)) begin
            arl_d = 1'b1;
        end
    end

    // Outputs
    always_comb begin
        src_en     = en_q;
        active_src = act_q;
        tgt_src    = tgt_q;
        state      = st_q;
        rdy_flag   = rdy_q;
        sut_out    = sut_q;
        arl_req    = arl_q;
    end

endmodule

// File: rtl/clksrc_regif.sv
module clksrc_regif
    import clksrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              cmd_fire,
    input  logic [3:0]        cmd_code,
    input  logic              win_open,
    input  state_e            state,
    input  logic              rdy_flag,
    input  logic [SRC_W-1:0]  active_src,
    output logic [SRC_W-1:0]  sel_num,
    output logic [SUT_W-1:0]  sel_sut,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int SEL_W = SRC_W + SUT_W;

    logic [SEL_W-1:0] sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (bus_wr && bus_addr) begin
            sel_q <= bus_wdata[SEL_W-1:0];
        end else if (cmd_fire && (cmd_code == CMD_RECOVER)) begin
            sel_q[SRC_W-1:0] <= active_src;
        end
    end

    assign sel_num = sel_q[SRC_W-1:0];
    assign sel_sut = sel_q[SEL_W-1:SRC_W];

    always_comb begin
        if (bus_addr) begin
            bus_rdata = {{(DATA_W - SEL_W){1'b0}}, sel_q};
        end else begin
            bus_rdata = {win_open,
                         state == ST_SWITCHING,
                         state == ST_WAIT_READY,
                         rdy_flag,
                         4'h0};
        end
    end

endmodule

// File: rtl/clksrc_cmd_ctrl.sv
module clksrc_cmd_ctrl
    import clksrc_pkg::*;
#(
    parameter int NSRC       = 6,
    parameter int WIN_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [NSRC-1:0]   src_ready,
    input  logic              mux_ack,
    output logic [NSRC-1:0]   src_en,
    output logic [1:0]        osc_startup,
    output logic              mux_req,
    output logic [3:0]        mux_target,
    output logic [3:0]        active_src,
    output logic              wdog_autoreload
);

    logic             win_open;
    logic             cmd_fire;
    logic [3:0]       cmd_code;
    logic [SRC_W-1:0] sel_num;
    logic [SUT_W-1:0] sel_sut;
    logic [SRC_W-1:0] tgt_src;
    state_e           state;
    logic             rdy_flag;

    clksrc_guard #(.WIN_CYCLES(WIN_CYCLES)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .win_open  (win_open),
        .cmd_fire  (cmd_fire),
        .cmd_code  (cmd_code)
    );

    clksrc_fsm #(.NSRC(NSRC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_fire   (cmd_fire),
        .cmd_code   (cmd_code),
        .sel_num    (sel_num),
        .sel_sut    (sel_sut),
        .src_ready  (src_ready),
        .mux_ack    (mux_ack),
        .src_en     (src_en),
        .active_src (active_src),
        .tgt_src    (tgt_src),
        .state      (state),
        .rdy_flag   (rdy_flag),
        .sut_out    (osc_startup),
        .arl_req    (wdog_autoreload)
    );

    clksrc_regif u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cmd_fire   (cmd_fire),
        .cmd_code   (cmd_code),
        .win_open   (win_open),
        .state      (state),
        .rdy_flag   (rdy_flag),
        .active_src (active_src),
        .sel_num    (sel_num),
        .sel_sut    (sel_sut),
        .bus_rdata  (bus_rdata)
    );

    assign mux_req    = (state == ST_SWITCHING);
    assign mux_target = tgt_src;

endmodule

// File: rtl/clksrc_cmd_ctrl_sva.sv
module clksrc_cmd_ctrl_sva #(
    parameter int NSRC = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic            bus_addr,
    input logic [NSRC-1:0] src_ready,
    input logic            mux_ack,
    input logic [NSRC-1:0] src_en,
    input logic            mux_req,
    input logic [3:0]      mux_target,
    input logic [3:0]      active_src,
    input logic            wdog_autoreload,
    input logic            win_open,
    input logic            rdy_flag,
    input logic [3:0]      tgt_src
);

    // R1: values seen one clock after reset is sampled low
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (active_src == 4'd0 && src_en == NSRC'(1) && !rdy_flag
                    && !wdog_autoreload && !win_open && !mux_req));

    // R2: a control write outside the window leaves enables and arl untouched
    a_r2_closed_window: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && !win_open) |=> ($stable(src_en) && $stable(wdog_autoreload)));

    // R5: ready only rises for an enabled target that reported ready
    a_r5_ready_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_flag) |-> (|(src_en & (NSRC'(1) << tgt_src))
                             && $past(|(src_ready & (NSRC'(1) << tgt_src)))));

    // R6: active source moves only on a sampled acknowledge
    a_r6_active_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_src) |-> $past(mux_req && mux_ack));

    // R8: the active source is never disabled
    a_r8_active_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        |(src_en & (NSRC'(1) << active_src)));

    // R9: request and target hold until acknowledged
    a_r9_switch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_req && !mux_ack) |=> (mux_req && $stable(mux_target)));

    // R10: auto-reload request is sticky
    a_r10_arl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_autoreload |=> wdog_autoreload);

endmodule

bind clksrc_cmd_ctrl clksrc_cmd_ctrl_sva #(.NSRC(NSRC)) u_sva (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_wr          (bus_wr),
    .bus_addr        (bus_addr),
    .src_ready       (src_ready),
    .mux_ack         (mux_ack),
    .src_en          (src_en),
    .mux_req         (mux_req),
    .mux_target      (mux_target),
    .active_src      (active_src),
    .wdog_autoreload (wdog_autoreload),
    .win_open        (win_open),
    .rdy_flag        (rdy_flag),
    .tgt_src         (tgt_src)
);

// File: tb/clksrc_cmd_ctrl_tb.sv
module clksrc_cmd_ctrl_tb;

    localparam int NSRC = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic            bus_addr = 1'b0;
    logic [7:0]      bus_wdata = 8'h00;
    logic [7:0]      bus_rdata;
    logic [NSRC-1:0] src_ready = '0;
    logic            mux_ack = 1'b0;
    logic [NSRC-1:0] src_en;
    logic [1:0]      osc_startup;
    logic            mux_req;
    logic [3:0]      mux_target;
    logic [3:0]      active_src;
    logic            wdog_autoreload;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    clksrc_cmd_ctrl #(.NSRC(NSRC), .WIN_CYCLES(4)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_wr          (bus_wr),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .src_ready       (src_ready),
        .mux_ack         (mux_ack),
        .src_en          (src_en),
        .osc_startup     (osc_startup),
        .mux_req         (mux_req),
        .mux_target      (mux_target),
        .active_src      (active_src),
        .wdog_autoreload (wdog_autoreload)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- environment: oscillators and multiplexer ----------------
    int osc_cnt [NSRC];
    int mux_cnt = 0;
    always @(posedge clk) begin
        #1;
        for (int i = 0; i < NSRC; i++) begin
            if (!rst_n || !src_en[i]) osc_cnt[i] = 0;
            else if (osc_cnt[i] < 1000) osc_cnt[i]++;
            src_ready[i] = rst_n && src_en[i] && (osc_cnt[i] >= 3 * i + 2);
        end
        if (!rst_n || !mux_req) begin
            mux_cnt = 0;
            mux_ack = 1'b0;
        end else begin
            mux_cnt++;
            mux_ack = (mux_cnt == 3);
        end
    end

    // ---------------- behavioural reference model ----------------
    int   m_win = 0;
    int   m_sel = 0;
    int   m_en  = 1;
    int   m_act = 0;
    int   m_tgt = 0;
    int   m_rdy = 0;
    int   m_sut = 0;
    int   m_arl = 0;
    int   m_st  = 0;   // 0 idle, 1 waiting for ready, 2 switching

    always @(posedge clk) begin
        if (!rst_n) begin
            m_win = 0; m_sel = 0; m_en = 1; m_act = 0; m_tgt = 0;
            m_rdy = 0; m_sut = 0; m_arl = 0; m_st = 0;
        end else begin
            bit fire;
            int s, code, old_act;
            fire    = bus_wr && !bus_addr && (m_win > 0) && (bus_wdata[7:4] == 4'h0);
            code    = int'(bus_wdata[3:0]);
            s       = m_sel % 16;
            old_act = m_act;
            if (m_st == 1) begin
                if (((int'(src_ready) >> m_tgt) & 1) == 1) begin
                    m_rdy = 1; m_st = 0;
                end
            end else if (m_st == 2) begin
                if (mux_ack) begin
                    m_act = m_tgt; m_st = 0;
                end
            end else if (fire) begin
                if (code == 2 && s < NSRC) begin
                    m_en = m_en | (1 << s); m_rdy = 0; m_tgt = s;
                    m_sut = m_sel / 16; m_st = 1;
                end else if (code == 4 && s < NSRC && ((m_en >> s) & 1) == 1) begin
                    m_tgt = s; m_st = 2;
                end else if (code == 1 && s < NSRC && s != m_act) begin
                    m_en = m_en & ~(1 << s);
                end
            end
            if (fire && code == 5) m_sel = (m_sel & 'h30) | old_act;
            if (fire && code == 6) m_arl = 1;
            if (bus_wr && !bus_addr && bus_wdata == 8'h80) m_win = 4;
            else if (bus_wr) m_win = 0;
            else if (m_win > 0) m_win--;
            if (bus_wr && bus_addr) m_sel = int'(bus_wdata[5:0]);
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int exp_rd;
            if (bus_addr) exp_rd = m_sel;
            else exp_rd = ((m_win > 0) << 7) | ((m_st == 2) << 6) | ((m_st == 1) << 5) | (m_rdy << 4);
            chk(bus_addr ? "R4 model select read" : "R5 model status read", int'(bus_rdata), exp_rd);
            chk("R8 model src_en", int'(src_en), m_en);
            chk("R6 model active_src", int'(active_src), m_act);
            chk("R9 model mux_req", int'(mux_req), int'(m_st == 2));
            if (mux_req) chk("R9 model mux_target", int'(mux_target), m_tgt);
            chk("R10 model wdog_autoreload", int'(wdog_autoreload), m_arl);
            chk("R12 model osc_startup", int'(osc_startup), m_sut);
        end
    end

    // ---------------- stimulus helpers (called at posedge + 2) ----------------
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] c);
        wr(1'b0, 8'h80);
        wr(1'b0, c);
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle(input int limit);
        logic [7:0] d;
        for (int i = 0; i < limit; i++) begin
            rd(1'b0, d);
            if (d[6:5] == 2'b00) break;
            tick();
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 active_src after reset", int'(active_src), 0);
        chk("R1 src_en after reset", int'(src_en), 1);
        rd(1'b0, d);
        chk("R1 status after reset", int'(d), 0);
        chk("R1 autoreload after reset", int'(wdog_autoreload), 0);
        tick();

        // R4 select layout
        wr(1'b1, 8'h23);
        rd(1'b1, d);
        chk("R4 select readback", int'(d), 'h23);
        wr(1'b1, 8'hE2);
        rd(1'b1, d);
        chk("R4 select upper bits dropped", int'(d), 'h22);

        // R2 window too late (gap of 5 cycles)
        wr(1'b0, 8'h80);
        idle(4);
        wr(1'b0, 8'h02);
        chk("R2 late command ignored", int'(src_en), 1);
        // R2 intervening write closes window
        wr(1'b0, 8'h80);
        wr(1'b1, 8'h22);
        wr(1'b0, 8'h02);
        chk("R2 command after other write ignored", int'(src_en), 1);
        // R2 last legal cycle of window
        wr(1'b0, 8'h80);
        rd(1'b0, d);
        chk("R2 window flag open", int'(d[7]), 1);
        idle(3);
        wr(1'b0, 8'h02);
        chk("R2 R3 enable in last window cycle", int'(src_en), 'h5);
        chk("R12 startup code captured", int'(osc_startup), 2);
        rd(1'b0, d);
        chk("R5 ready cleared while waiting", int'(d[5:4]), 2'b10);
        wait_idle(100);
        rd(1'b0, d);
        chk("R5 ready flag set", int'(d[4]), 1);
        tick();

        // R3 invalid code has no effect
        cmd(8'h03);
        chk("R3 invalid code no effect", int'(src_en), 'h5);

        // R6 switch to source 2 with recover during switching (R7)
        cmd(8'h04);
        chk("R6 mux_req raised", int'(mux_req), 1);
        cmd(8'h05);
        rd(1'b1, d);
        chk("R7 recover mid-switch returns old source", int'(d), 'h20);
        wait_idle(50);
        chk("R6 active after ack", int'(active_src), 2);
        tick();
        cmd(8'h05);
        rd(1'b1, d);
        chk("R7 recover after switch", int'(d), 'h22);

        // R8 disable the active source is refused
        cmd(8'h01);
        chk("R8 active source kept", int'(src_en), 'h5);
        wr(1'b1, 8'h00);
        cmd(8'h01);
        chk("R8 old source disabled", int'(src_en), 'h4);

        // R6 switch to a disabled source is ignored
        cmd(8'h04);
        chk("R6 switch to disabled ignored", int'(mux_req), 0);
        chk("R6 active unchanged", int'(active_src), 2);

        // R9 enable while waiting is ignored
        wr(1'b1, 8'h13);
        cmd(8'h02);
        wr(1'b1, 8'h04);
        cmd(8'h02);
        chk("R9 enable while busy ignored", int'(src_en), 'h0C);
        wait_idle(100);
        rd(1'b0, d);
        chk("R5 ready after slow source", int'(d[4]), 1);
        chk("R12 startup code kept", int'(osc_startup), 1);
        tick();

        // R11 out-of-range numbers
        wr(1'b1, 8'h09);
        cmd(8'h02);
        rd(1'b0, d);
        chk("R11 out-of-range enable ignored", int'(d[5]), 0);
        chk("R11 src_en unchanged", int'(src_en), 'h0C);
        cmd(8'h04);
        chk("R11 out-of-range switch ignored", int'(mux_req), 0);

        // R10 watchdog auto-reload is sticky
        cmd(8'h06);
        chk("R10 autoreload set", int'(wdog_autoreload), 1);
        idle(3);
        chk("R10 autoreload held", int'(wdog_autoreload), 1);

        idle(2);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule